// File: doc/BRIEF.md
# Transceiver Configuration Sequencer

This block sits on the host side of a four-channel serial transceiver and drives the transceiver's latch-bank write port. A start pulse launches one of two jobs. A full bring-up pulses the device reset low and resets the test-port state machine. It then writes the receive static, transmit static and dynamic latch banks of every channel, and finally resets each channel's phase-alignment buffer. A live reconfiguration touches one channel only and issues no reset.

Each bank write is skipped or merged where it can be. A static bank write is dropped when the target value already equals what the latch holds. The sequencer tracks the latch contents itself, and the device reset restores the default values. During a full bring-up, a bank whose target is the same on all channels is written once at the broadcast address. The phase-alignment reset is a pair of dynamic-bank writes, the first with the reset bit set and the second with it cleared. It is skipped for channels whose buffer is bypassed.

One live change is not allowed. If a channel's receive latch has decoder bypass, clock select and rate all at 0, and the request sets both decoder bypass and clock select, the live job is turned into a full bring-up of every channel.

Top module: `xcvr_cfg_seq`

## Requirements
- R1: After `rst_ni` is released, `busy_o`, `done_o`, `wr_o` and `tms_o` are 0, and `dev_rst_no` and `trst_no` are 1.
- R2: A full bring-up first holds `dev_rst_no` low for exactly RST_CYCLES cycles, with `trst_no` low and `tms_o` high over the same window (at least MIN_TMS_CYCLES). No write occurs while `dev_rst_no` is low.
- R3: The banks are written in this order: receive static, transmit static, dynamic, then the phase-alignment reset. Channel c uses addresses 3c (receive), 3c+1 (transmit) and 3c+2 (dynamic). The broadcast addresses are 12, 13 and 14. Channels go in ascending order, and address 15 is never written.
- R4: A receive or transmit static write is skipped when its target equals the value the latch currently holds. After a device reset the latches hold 0xBF (receive) and 0xAD (transmit).
- R5: The dynamic bank is always written. Its bit 1 (the phase-alignment reset bit) is forced to 0.
- R6: The phase-alignment reset writes the dynamic value with bit 1 set, then, in the very next cycle, writes the same address with bit 1 cleared. Channels whose bit of `pab_bypass_i` is 1 get no such pair.
- R7: In a full bring-up, a step whose value is equal on all channels is written once at the broadcast address. For the phase-alignment step this also requires that no channel is bypassed. Otherwise the step is written per channel.
- R8: A start with `all_ch_i`=0 and no forbidden change writes only the addresses of channel `chan_i` and leaves `dev_rst_no` and `trst_no` high.
- R9: If the selected channel's receive latch has bits 3, 2 and 1 all at 0, and the target sets bits 3 and 2, the job becomes a full bring-up of all channels.
- R10: `busy_o` rises in the cycle after an accepted start and stays high through the last step. `done_o` is high for exactly one cycle, which is the first cycle with `busy_o` low.
- R11: A start pulse that arrives while `busy_o` is high is ignored. It starts no second job, and no write follows `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset of the sequencer |
| start_i | input | 1 | Start pulse, accepted only when idle |
| all_ch_i | input | 1 | 1: full bring-up of all channels; 0: live change of one channel |
| chan_i | input | 2 | Channel selected for a live change |
| tgt_rx_i | input | 32 | Receive static targets, channel c in bits [8c+7:8c] |
| tgt_tx_i | input | 32 | Transmit static targets, same packing |
| tgt_dyn_i | input | 32 | Dynamic bank targets, same packing |
| pab_bypass_i | input | 4 | Per-channel phase-alignment buffer bypassed |
| addr_o | output | 4 | Latch-bank address |
| data_o | output | 8 | Latch-bank write data |
| wr_o | output | 1 | Write strobe, one write per cycle |
| dev_rst_no | output | 1 | Device reset, active low |
| trst_no | output | 1 | Test-port reset, active low |
| tms_o | output | 1 | Test mode select, high during test-port reset |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
The hardest case to reach from the ports is the forbidden live change. The selected channel's latch must first hold decoder bypass, clock select and rate all at 0, and that state only exists after an earlier job has written it. The stimulus therefore runs a full bring-up that loads that value into one channel, then requests the forbidden live change on that channel and expects a reset pulse. As a control, a near-miss request that sets only decoder bypass must stay live. The broadcast-versus-per-channel choice is also driven on purpose: random targets are copied from channel 0 part of the time, so both uniform and mixed steps occur.

// File: rtl/xcvr_cfg_pkg.sv
package xcvr_cfg_pkg;

    // Width of one latch bank as seen at the device write port.
    localparam int LATCH_W = 8;

    // Banks per channel and their offsets inside a channel's address group.
    localparam int BANKS_PER_CH = 3;
    localparam int OFF_RX  = 0;
    localparam int OFF_TX  = 1;
    localparam int OFF_DYN = 2;

    // Values the device restores on its own reset.
    localparam logic [LATCH_W-1:0] RX_DEFAULT = 8'hBF;
    localparam logic [LATCH_W-1:0] TX_DEFAULT = 8'hAD;

    // Receive static field positions used by the live-change check.
    localparam int BIT_DEC_BYPASS = 3;
    localparam int BIT_RX_CLKSEL  = 2;
    localparam int BIT_RX_RATE    = 1;

    // Phase-alignment buffer reset bit in the dynamic bank.
    localparam int BIT_PAB_RST = 1;
    localparam logic [LATCH_W-1:0] PAB_MASK = LATCH_W'(1) << BIT_PAB_RST;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_RX,
        ST_TX,
        ST_DYN,
        ST_PSET,
        ST_PCLR
    } step_e;

endpackage

// File: rtl/xcvr_cfg_rstgen.sv
// Drives the device reset and the test-port reset over one shared window.
module xcvr_cfg_rstgen #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic launch_i,
    output logic active_o,
    output logic dev_rst_no,
    output logic trst_no,
    output logic tms_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (launch_i) begin
            cnt_d = CNT_W'(RST_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active_o   = (cnt_q != '0);
    assign dev_rst_no = ~active_o;
    assign trst_no    = ~active_o;
    assign tms_o      = active_o;

endmodule

// File: rtl/xcvr_cfg_shadow.sv
// Tracks what the device's static latches hold, from the writes issued.
module xcvr_cfg_shadow
    import xcvr_cfg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       clear_i,
    input  logic                       wr_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [LATCH_W-1:0]         data_i,
    output logic [NUM_CH*LATCH_W-1:0]  shd_rx_o,
    output logic [NUM_CH*LATCH_W-1:0]  shd_tx_o
);
    localparam int GLB_BASE = BANKS_PER_CH * NUM_CH;

    logic glb_rx_hit, glb_tx_hit;

    assign glb_rx_hit = wr_i && (addr_i == ADDR_W'(GLB_BASE + OFF_RX));
    assign glb_tx_hit = wr_i && (addr_i == ADDR_W'(GLB_BASE + OFF_TX));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [LATCH_W-1:0] rx_d, rx_q, tx_d, tx_q;
        logic               rx_hit, tx_hit;

        assign rx_hit = glb_rx_hit ||
                        (wr_i && (addr_i == ADDR_W'(BANKS_PER_CH * c + OFF_RX)));
        assign tx_hit = glb_tx_hit ||
                        (wr_i && (addr_i == ADDR_W'(BANKS_PER_CH * c + OFF_TX)));

        always_comb begin
            rx_d = rx_q;
            tx_d = tx_q;
            if (clear_i) begin
                rx_d = RX_DEFAULT;
                tx_d = TX_DEFAULT;
            end else begin
                if (rx_hit) rx_d = data_i;
                if (tx_hit) tx_d = data_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                rx_q <= RX_DEFAULT;
                tx_q <= TX_DEFAULT;
            end else begin
                rx_q <= rx_d;
                tx_q <= tx_d;
            end
        end

        assign shd_rx_o[c*LATCH_W +: LATCH_W] = rx_q;
        assign shd_tx_o[c*LATCH_W +: LATCH_W] = tx_q;
    end

endmodule

// File: rtl/xcvr_cfg_step.sv
// Decides, for the current step and channel index, whether and what to write.
module xcvr_cfg_step
    import xcvr_cfg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 2
) (
    input  step_e                      step_i,
    input  logic                       all_mode_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [IDX_W-1:0]           sel_i,
    input  logic [NUM_CH*LATCH_W-1:0]  tgt_rx_i,
    input  logic [NUM_CH*LATCH_W-1:0]  tgt_tx_i,
    input  logic [NUM_CH*LATCH_W-1:0]  tgt_dyn_i,
    input  logic [NUM_CH-1:0]          bypass_i,
    input  logic [NUM_CH*LATCH_W-1:0]  shd_rx_i,
    input  logic [NUM_CH*LATCH_W-1:0]  shd_tx_i,
    input  logic [NUM_CH*LATCH_W-1:0]  req_rx_i,
    output logic                       wr_o,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [LATCH_W-1:0]         data_o,
    output logic                       last_o,
    output logic [NUM_CH-1:0]          hazard_o
);
    localparam int GLB_BASE = BANKS_PER_CH * NUM_CH;

    logic [LATCH_W-1:0] val [NUM_CH];
    logic [LATCH_W-1:0] shd [NUM_CH];
    logic [NUM_CH-1:0]  need;
    logic [NUM_CH-1:0]  same;
    logic               is_static, is_pab, in_step, uniform;
    logic [IDX_W-1:0]   ch;
    int                 off;

    assign is_static = (step_i == ST_RX) || (step_i == ST_TX);
    assign is_pab    = (step_i == ST_PSET) || (step_i == ST_PCLR);
    assign in_step   = is_static || is_pab || (step_i == ST_DYN);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [LATCH_W-1:0] cur_rx;
        assign cur_rx = shd_rx_i[c*LATCH_W +: LATCH_W];

        assign val[c] = (step_i == ST_RX) ? tgt_rx_i[c*LATCH_W +: LATCH_W] :
                        (step_i == ST_TX) ? tgt_tx_i[c*LATCH_W +: LATCH_W] :
                        (tgt_dyn_i[c*LATCH_W +: LATCH_W] & ~PAB_MASK);
        assign shd[c] = (step_i == ST_TX) ? shd_tx_i[c*LATCH_W +: LATCH_W] : cur_rx;
        assign need[c] = is_static ? (val[c] != shd[c]) :
                         is_pab    ? ~bypass_i[c] :
                         (step_i == ST_DYN);
        assign same[c] = (val[c] == val[0]);

        // Live decoder/clock-select change that the device cannot take.
        assign hazard_o[c] = !cur_rx[BIT_DEC_BYPASS] && !cur_rx[BIT_RX_CLKSEL] &&
                             !cur_rx[BIT_RX_RATE] &&
                             req_rx_i[c*LATCH_W + BIT_DEC_BYPASS] &&
                             req_rx_i[c*LATCH_W + BIT_RX_CLKSEL];
    end

    assign uniform = (&same) && (!is_pab || (&need));

    always_comb begin
        wr_o   = 1'b0;
        addr_o = '0;
        data_o = '0;
        last_o = 1'b1;
        ch     = all_mode_i ? idx_i : sel_i;
        off    = (step_i == ST_RX) ? OFF_RX : (step_i == ST_TX) ? OFF_TX : OFF_DYN;
        if (in_step) begin
            if (all_mode_i && uniform) begin
                wr_o   = |need;
                addr_o = ADDR_W'(GLB_BASE + off);
                data_o = val[0];
                last_o = 1'b1;
            end else begin
                wr_o   = need[ch];
                addr_o = ADDR_W'(BANKS_PER_CH * int'(ch) + off);
                data_o = val[ch];
                last_o = !all_mode_i || (idx_i == IDX_W'(NUM_CH - 1));
            end
            if (step_i == ST_PSET) begin
                data_o = data_o | PAB_MASK;
            end
        end
    end

endmodule

// File: rtl/xcvr_cfg_seq.sv
module xcvr_cfg_seq
    import xcvr_cfg_pkg::*;
#(
    parameter int NUM_CH         = 4,
    parameter int RST_CYCLES     = 16,
    parameter int MIN_TMS_CYCLES = 5,
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = $clog2(BANKS_PER_CH * NUM_CH + BANKS_PER_CH + 1),
    localparam int VEC_W  = NUM_CH * LATCH_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               all_ch_i,
    input  logic [IDX_W-1:0]   chan_i,
    input  logic [VEC_W-1:0]   tgt_rx_i,
    input  logic [VEC_W-1:0]   tgt_tx_i,
    input  logic [VEC_W-1:0]   tgt_dyn_i,
    input  logic [NUM_CH-1:0]  pab_bypass_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [LATCH_W-1:0] data_o,
    output logic               wr_o,
    output logic               dev_rst_no,
    output logic               trst_no,
    output logic               tms_o,
    output logic               busy_o,
    output logic               done_o
);

    typedef struct packed {
        step_e              step;
        logic               all_mode;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   sel;
        logic               done;
        logic [VEC_W-1:0]   rx;
        logic [VEC_W-1:0]   tx;
        logic [VEC_W-1:0]   dyn;
        logic [NUM_CH-1:0]  byp;
    } seq_t;

    seq_t               seq_d, seq_q;
    logic               launch, rg_active, step_last;
    logic [NUM_CH-1:0]  hazard;
    logic [VEC_W-1:0]   shd_rx, shd_tx;

    xcvr_cfg_rstgen #(
        .RST_CYCLES (RST_CYCLES)
    ) u_rstgen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .launch_i   (launch),
        .active_o   (rg_active),
        .dev_rst_no (dev_rst_no),
        .trst_no    (trst_no),
        .tms_o      (tms_o)
    );

    xcvr_cfg_shadow #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_shadow (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (launch),
        .wr_i     (wr_o),
        .addr_i   (addr_o),
        .data_i   (data_o),
        .shd_rx_o (shd_rx),
        .shd_tx_o (shd_tx)
    );

    xcvr_cfg_step #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_step (
        .step_i     (seq_q.step),
        .all_mode_i (seq_q.all_mode),
        .idx_i      (seq_q.idx),
        .sel_i      (seq_q.sel),
        .tgt_rx_i   (seq_q.rx),
        .tgt_tx_i   (seq_q.tx),
        .tgt_dyn_i  (seq_q.dyn),
        .bypass_i   (seq_q.byp),
        .shd_rx_i   (shd_rx),
        .shd_tx_i   (shd_tx),
        .req_rx_i   (tgt_rx_i),
        .wr_o       (wr_o),
        .addr_o     (addr_o),
        .data_o     (data_o),
        .last_o     (step_last),
        .hazard_o   (hazard)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        launch     = 1'b0;
        unique case (seq_q.step)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.rx  = tgt_rx_i;
                    seq_d.tx  = tgt_tx_i;
                    seq_d.dyn = tgt_dyn_i;
                    seq_d.byp = pab_bypass_i;
                    seq_d.sel = chan_i;
                    seq_d.idx = '0;
                    if (all_ch_i || hazard[chan_i]) begin
                        seq_d.all_mode = 1'b1;
                        seq_d.step     = ST_RESET;
                        launch         = 1'b1;
                    end else begin
                        seq_d.all_mode = 1'b0;
                        seq_d.step     = ST_RX;
                    end
                end
            end
            ST_RESET: begin
                if (!rg_active) seq_d.step = ST_RX;
            end
            ST_RX, ST_TX, ST_DYN: begin
                if (step_last) begin
                    seq_d.idx  = '0;
                    seq_d.step = (seq_q.step == ST_RX) ? ST_TX :
                                 (seq_q.step == ST_TX) ? ST_DYN : ST_PSET;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            ST_PSET: begin
                seq_d.step = ST_PCLR;
            end
            ST_PCLR: begin
                if (step_last) begin
                    seq_d.step = ST_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.idx  = seq_q.idx + 1'b1;
                    seq_d.step = ST_PSET;
                end
            end
            default: begin
                seq_d.step = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q      <= '0;
            seq_q.step <= ST_IDLE;
        end else begin
            seq_q      <= seq_d;
        end
    end

    assign busy_o = (seq_q.step != ST_IDLE);
    assign done_o = seq_q.done;

endmodule

// File: rtl/xcvr_cfg_seq_chk.sv
module xcvr_cfg_seq_chk
    import xcvr_cfg_pkg::*;
#(
    parameter int NUM_CH         = 4,
    parameter int RST_CYCLES     = 16,
    parameter int MIN_TMS_CYCLES = 5,
    parameter int ADDR_W         = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [ADDR_W-1:0]  addr_o,
    input logic [LATCH_W-1:0] data_o,
    input logic               wr_o,
    input logic               dev_rst_no,
    input logic               trst_no,
    input logic               tms_o,
    input logic               busy_o,
    input logic               done_o
);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(BANKS_PER_CH * NUM_CH + 3);

    logic [31:0] low_run, tms_run;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            low_run <= '0;
            tms_run <= '0;
        end else begin
            low_run <= dev_rst_no ? 32'd0 : low_run + 32'd1;
            tms_run <= tms_o ? tms_run + 32'd1 : 32'd0;
        end
    end

    // R2: no write while the device is held in reset
    a_r2_no_write_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dev_rst_no |-> !wr_o);

    // R2: device reset low for exactly the programmed length
    a_r2_reset_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dev_rst_no) |-> (low_run == 32'(RST_CYCLES)));

    // R2: test-mode select held high long enough before test reset release
    a_r2_tms_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(trst_no) |-> (tms_run >= 32'(MIN_TMS_CYCLES)));

    // R3: mask address never written
    a_r3_no_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_o |-> (addr_o != MASK_ADDR));

    // R6: buffer reset set is followed by a clear of the same dynamic bank
    a_r6_pab_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_o && data_o[BIT_PAB_RST] && ((addr_o % 3) == 2))
        |=> (wr_o && (addr_o == $past(addr_o)) && !data_o[BIT_PAB_RST]));

    // R10: writes only while busy
    a_r10_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_o |-> busy_o);

    // R10: done marks the first idle cycle after a job
    a_r10_done_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

endmodule

bind xcvr_cfg_seq xcvr_cfg_seq_chk #(
    .NUM_CH         (NUM_CH),
    .RST_CYCLES     (RST_CYCLES),
    .MIN_TMS_CYCLES (MIN_TMS_CYCLES),
    .ADDR_W         (ADDR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_o     (addr_o),
    .data_o     (data_o),
    .wr_o       (wr_o),
    .dev_rst_no (dev_rst_no),
    .trst_no    (trst_no),
    .tms_o      (tms_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/tb_xcvr_cfg_seq.sv
module tb_xcvr_cfg_seq;
    localparam int NCH   = 4;
    localparam int RSTC  = 16;
    localparam logic [7:0] DEF_RX = 8'hBF;
    localparam logic [7:0] DEF_TX = 8'hAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        all_ch = 1'b0;
    logic [1:0]  chan = '0;
    logic [31:0] rx_v, tx_v, dyn_v;
    logic [3:0]  byp = '0;
    logic [3:0]  addr;
    logic [7:0]  data;
    logic        wr, dev_rst_n, trst_n, tms, busy, done;

    logic [7:0]  t_rx [NCH];
    logic [7:0]  t_tx [NCH];
    logic [7:0]  t_dyn [NCH];
    logic [7:0]  m_rx [NCH];
    logic [7:0]  m_tx [NCH];
    logic [11:0] exp_w [64];
    logic [11:0] got_w [64];
    int          n_exp, n_got;
    bit          exp_full;
    int          compared = 0;
    int          mismatched = 0;
    int          cycles = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            rx_v[c*8 +: 8]  = t_rx[c];
            tx_v[c*8 +: 8]  = t_tx[c];
            dyn_v[c*8 +: 8] = t_dyn[c];
        end
    end

    xcvr_cfg_seq #(.NUM_CH(NCH), .RST_CYCLES(RSTC), .MIN_TMS_CYCLES(5)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .all_ch_i(all_ch), .chan_i(chan),
        .tgt_rx_i(rx_v), .tgt_tx_i(tx_v), .tgt_dyn_i(dyn_v), .pab_bypass_i(byp),
        .addr_o(addr), .data_o(data), .wr_o(wr), .dev_rst_no(dev_rst_n),
        .trst_no(trst_n), .tms_o(tms), .busy_o(busy), .done_o(done));

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", cycles);
            summary();
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, expv);
        end
    endtask

    // ---------------- reference model of the requirements ----------------
    function automatic logic [7:0] step_val(int s, int c);
        if (s == 0) return t_rx[c];
        if (s == 1) return t_tx[c];
        return t_dyn[c] & 8'hFD;
    endfunction

    function automatic logic [7:0] latch_val(int s, int c);
        return (s == 0) ? m_rx[c] : m_tx[c];
    endfunction

    function automatic void push(int a, logic [7:0] d);
        exp_w[n_exp] = {4'(a), d};
        n_exp++;
        if (a < 12) begin
            if (a % 3 == 0) m_rx[a/3] = d;
            if (a % 3 == 1) m_tx[a/3] = d;
        end
        if (a == 12) for (int c = 0; c < NCH; c++) m_rx[c] = d;
        if (a == 13) for (int c = 0; c < NCH; c++) m_tx[c] = d;
    endfunction

    function automatic void build_exp(bit all, int ch);
        bit uni, need;
        n_exp = 0;
        exp_full = all || (m_rx[ch][3:1] == 3'b000 && t_rx[ch][3] && t_rx[ch][2]);
        if (exp_full) begin
            for (int c = 0; c < NCH; c++) begin m_rx[c] = DEF_RX; m_tx[c] = DEF_TX; end
        end
        for (int s = 0; s < 3; s++) begin
            if (exp_full) begin
                uni = 1; need = (s == 2);
                for (int c = 0; c < NCH; c++) begin
                    if (step_val(s, c) != step_val(s, 0)) uni = 0;
                    if (s < 2 && step_val(s, c) != latch_val(s, c)) need = 1;
                end
                if (uni) begin
                    if (need) push(12 + s, step_val(s, 0));
                end else begin
                    for (int c = 0; c < NCH; c++)
                        if (s == 2 || step_val(s, c) != latch_val(s, c)) push(3*c + s, step_val(s, c));
                end
            end else if (s == 2 || step_val(s, ch) != latch_val(s, ch)) begin
                push(3*ch + s, step_val(s, ch));
            end
        end
        if (exp_full) begin
            uni = (byp == 4'b0000);
            for (int c = 0; c < NCH; c++) if (step_val(2, c) != step_val(2, 0)) uni = 0;
            if (uni) begin
                push(14, step_val(2, 0) | 8'h02); push(14, step_val(2, 0));
            end else begin
                for (int c = 0; c < NCH; c++)
                    if (!byp[c]) begin push(3*c+2, step_val(2, c) | 8'h02); push(3*c+2, step_val(2, c)); end
            end
        end else if (!byp[ch]) begin
            push(3*ch+2, step_val(2, ch) | 8'h02); push(3*ch+2, step_val(2, ch));
        end
    endfunction

    // ---------------- one job: drive, observe, compare ----------------
    task automatic run_job(bit all, int ch, int restart_at, string req);
        int lo = 0, trst_lo = 0, tms_hi = 0, cyc = 0, wr_rst = 0, dones = 0;
        bit fin = 0;
        build_exp(all, ch);
        n_got = 0;
        @(negedge clk);
        all_ch = all; chan = 2'(ch); start = 1'b1;
        while (!fin && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = 1'b0;
                chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
            end
            if (cyc == restart_at) start = 1'b1;
            if (cyc == restart_at + 1) start = 1'b0;
            if (!dev_rst_n) lo++;
            if (!trst_n) trst_lo++;
            if (tms) tms_hi++;
            if (wr) begin
                if (!dev_rst_n) wr_rst++;
                if (n_got < 64) got_w[n_got] = {addr, data};
                n_got++;
            end
            if (done) begin
                fin = 1;
                dones++;
                chk(busy == 1'b0, "R10", "busy low with done", int'(busy), 0);
            end
        end
        chk(fin, "R10", "job finished", int'(fin), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (done) dones++;
            chk(!wr && !busy, "R11", "quiet after done", int'({wr, busy}), 0);
        end
        chk(dones == 1, "R10", "done pulses", dones, 1);
        if (exp_full) begin
            chk(lo == RSTC, "R2", "device reset cycles", lo, RSTC);
            chk(trst_lo == RSTC && tms_hi >= 5, "R2", "test reset cycles", trst_lo, RSTC);
            chk(wr_rst == 0, "R2", "writes during reset", wr_rst, 0);
        end else begin
            chk(lo == 0 && trst_lo == 0, "R8", "no reset on live job", lo + trst_lo, 0);
        end
        chk(n_got == n_exp, req, "write count", n_got, n_exp);
        for (int k = 0; k < n_exp && k < n_got; k++)
            chk(got_w[k] == exp_w[k], req, $sformatf("write %0d {addr,data}", k),
                int'(got_w[k]), int'(exp_w[k]));
    endtask

    task automatic set_all(logic [7:0] rx, logic [7:0] tx, logic [7:0] dy);
        for (int c = 0; c < NCH; c++) begin t_rx[c] = rx; t_tx[c] = tx; t_dyn[c] = dy; end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1CE5EED);
        for (int c = 0; c < NCH; c++) begin m_rx[c] = DEF_RX; m_tx[c] = DEF_TX; end
        set_all(DEF_RX, DEF_TX, 8'hB3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(!busy && !done && !wr, "R1", "busy/done/wr", int'({busy, done, wr}), 0);
        chk(dev_rst_n && trst_n && !tms, "R1", "reset pins", int'({dev_rst_n, trst_n, tms}), 6);

        // R5/R4: defaults only -> static skipped, dynamic and buffer reset at broadcast
        run_job(1, 0, 0, "R5");
        chk(n_got == 3 && got_w[0] == {4'd14, 8'hB1}, "R5", "dynamic bit1 cleared",
            int'(got_w[0]), int'({4'd14, 8'hB1}));

        // R7: uniform receive setting, mixed dynamic values
        set_all(8'h55, DEF_TX, 8'h33);
        t_dyn[2] = 8'h71;
        run_job(1, 0, 0, "R7");

        // R6: bypassed buffers on channels 0 and 2
        set_all(8'h55, 8'h2C, 8'h30);
        byp = 4'b0101;
        run_job(1, 0, 0, "R6");
        byp = 4'b0000;

        // R3: every channel different
        for (int c = 0; c < NCH; c++) begin
            t_rx[c] = 8'h10 + 8'(c); t_tx[c] = 8'h20 + 8'(c); t_dyn[c] = 8'h40 + 8'(4*c);
        end
        run_job(1, 0, 0, "R3");

        // R8: live change of channel 2 transmit bank only
        t_tx[2] = 8'h6E;
        run_job(0, 2, 0, "R8");
        // R4: live job with static targets already in the latches
        run_job(0, 1, 0, "R4");

        // R9: load the restricted receive state into channel 1, then request the forbidden change
        set_all(DEF_RX, DEF_TX, 8'hB3);
        t_rx[1] = 8'hB1;
        run_job(1, 0, 0, "R9");
        t_rx[1] = 8'hBD;
        run_job(0, 1, 0, "R9");
        chk(exp_full == 1'b1, "R9", "escalation expected by model", int'(exp_full), 1);
        // R9 control: back to restricted state live, then a change that sets only decoder bypass
        t_rx[1] = 8'hB1;
        run_job(0, 1, 0, "R9");
        t_rx[1] = 8'hB9;
        run_job(0, 1, 0, "R9");

        // R11: extra start pulse mid-job is ignored
        t_tx[3] = 8'h0F;
        run_job(1, 0, 6, "R11");
        t_rx[0] = 8'h77;
        run_job(0, 0, 2, "R11");

        // Random jobs, channel values sometimes copied from channel 0
        for (int n = 0; n < 40; n++) begin
            for (int c = 0; c < NCH; c++) begin
                t_rx[c]  = ($urandom % 3 == 0) ? DEF_RX : 8'($urandom);
                t_tx[c]  = ($urandom % 3 == 0) ? DEF_TX : 8'($urandom);
                t_dyn[c] = 8'($urandom);
                if (c > 0 && ($urandom % 2 == 0)) begin
                    t_rx[c] = t_rx[0]; t_tx[c] = t_tx[0]; t_dyn[c] = t_dyn[0];
                end
            end
            byp = ($urandom % 2 == 0) ? 4'b0000 : 4'($urandom);
            run_job(($urandom % 3) == 0, int'($urandom % NCH), 0, "R3");
        end

        summary();
    end

endmodule